// File: doc/BRIEF.md
# Sound Generator Bus Register File

This block sits between a processor bus and the sound core of a programmable sound generator. Three control lines (BDIR, BC2, BC1) are sampled on each rising clock edge and decoded into one of four operations. The operations are: latch the data input as a register address, write the data input into the addressed register, read the addressed register back, or do nothing. Sixteen 8-bit registers are held here. Readback clears the bits each register does not implement.

Every register write that lands is also passed on to the sound core as a one-cycle strobe that carries the address and the data. A write to the envelope shape register (13) also raises an envelope restart pulse.

Two 8-bit general-purpose ports, A and B, are backed by registers 14 and 15. Bits 6 and 7 of the mixer register (7) set whether each port drives its pins or acts as an input. Pins of a port in input mode read high, as if pulled up.

Top module: `psg_bus_regfile`

## Requirements
- R1: Each of the control patterns {BDIR,BC2,BC1} = 111, 100 and 001, when sampled at a rising edge, latches the full 8-bit data input as the register address.
- R2: Pattern 110 is a write that stores the data input into the register at the latched address at the sampling edge. Pattern 011 is a read that drives the masked register value on the data output combinationally.
- R3: While the latched address is above 15, a write changes no register and raises no strobe, and a read returns 0xFF.
- R4: The patterns 000, 010 and 101 latch nothing and write nothing. Whenever the pattern is not 011, the data output is 0xFF.
- R5: Readback masks: registers 1, 3, 5 and 13 return only bits 3:0; registers 6, 8, 9 and 10 return only bits 4:0; all others return all 8 bits.
- R6: Port A pins show register 14 when bit 6 of register 7 is 1 and 0xFF otherwise. Port B pins show register 15 when bit 7 of register 7 is 1 and 0xFF otherwise. Pins follow a write from the cycle after its edge.
- R7: A read of register 14 or 15 returns the port's pin input ANDed with its register in output mode, or the pin input alone in input mode.
- R8: The first edge of a write to a valid address produces a one-cycle strobe in the following cycle, carrying the 4-bit address and the data. While a write is held over several edges, the register takes each new value but no further strobe is raised.
- R9: The envelope restart output pulses together with, and only with, a strobe whose address is 13.
- R10: Reset clears all registers and the latched address to 0, which leaves both ports in input mode, and holds the strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bus is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bdir | input | 1 | Bus direction control line |
| bc2 | input | 1 | Bus control line 2 |
| bc1 | input | 1 | Bus control line 1 |
| din | input | 8 | Data bus input (address or write data) |
| dout | output | 8 | Data bus output; 0xFF unless reading |
| port_a_in | input | 8 | External levels on port A pins |
| port_b_in | input | 8 | External levels on port B pins |
| port_a_out | output | 8 | Value driven on port A pins |
| port_b_out | output | 8 | Value driven on port B pins |
| wr_stb | output | 1 | One-cycle register write strobe to the sound core |
| wr_addr | output | 4 | Register address carried by the strobe |
| wr_data | output | 8 | Data carried by the strobe |
| env_restart | output | 1 | Envelope restart pulse on a shape register write |

## Verification
The bench builds the block with its default parameters: 8-bit data and sixteen registers. With these values the 8-bit address latch can hold addresses above the register count, so the ignored-write and 0xFF-read paths at address 16 can be exercised. Every readback mask and both port directions can also be reached in a short directed run. A write held over three edges exercises the rule that it gives one strobe while still updating the register.

// File: rtl/psg_bus_pkg.sv
package psg_bus_pkg;
    localparam int PSG_DW   = 8;
    localparam int PSG_NREG = 16;
    localparam int PSG_IW   = $clog2(PSG_NREG);
    localparam int MIX_IDX   = 7;
    localparam int SHAPE_IDX = 13;
    localparam int PORT0_IDX = 14;
    localparam int PORT0_DIR = 6;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_LATCH,
        OP_WRITE,
        OP_READ
    } bus_op_e;

    typedef struct packed {
        logic [PSG_DW-1:0] addr;
        logic              was_wr;
        logic              stb;
        logic [PSG_IW-1:0] stb_addr;
        logic [PSG_DW-1:0] stb_data;
        logic              restart;
    } bank_ctl_t;

    function automatic logic [PSG_DW-1:0] reg_mask(input logic [PSG_IW-1:0] idx);
        logic [PSG_DW-1:0] m;
        case (idx)
            4'd1, 4'd3, 4'd5, 4'd13: m = 8'h0F;
            4'd6, 4'd8, 4'd9, 4'd10: m = 8'h1F;
            default:                 m = 8'hFF;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/psg_bus_decode.sv
module psg_bus_decode
    import psg_bus_pkg::*;
(
    input  logic    bdir,
    input  logic    bc2,
    input  logic    bc1,
    output bus_op_e op
);
    always_comb begin
        case ({bdir, bc2, bc1})
            3'b111, 3'b100, 3'b001: op = OP_LATCH;
            3'b110:                 op = OP_WRITE;
            3'b011:                 op = OP_READ;
            default:                op = OP_IDLE;
        endcase
    end
endmodule

// File: rtl/psg_reg_bank.sv
module psg_reg_bank
    import psg_bus_pkg::*;
#(
    parameter int DATA_W   = PSG_DW,
    parameter int NUM_REGS = PSG_NREG,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  bus_op_e                           op,
    input  logic [DATA_W-1:0]                 din,
    output logic [DATA_W-1:0]                 addr_o,
    output logic [NUM_REGS-1:0][DATA_W-1:0]   regs_o,
    output logic                              wr_stb,
    output logic [IDX_W-1:0]                  wr_addr,
    output logic [DATA_W-1:0]                 wr_data,
    output logic                              env_restart
);
    bank_ctl_t                            ctl_d, ctl_q;
    logic [NUM_REGS-1:0][DATA_W-1:0]      regs_d, regs_q;
    logic                                 addr_ok;
    logic [IDX_W-1:0]                     idx;

    always_comb begin
        ctl_d         = ctl_q;
        regs_d        = regs_q;
        ctl_d.stb     = 1'b0;
        ctl_d.restart = 1'b0;
        addr_ok       = ctl_q.addr < DATA_W'(NUM_REGS);
        idx           = ctl_q.addr[IDX_W-1:0];
        case (op)
            OP_LATCH: ctl_d.addr = din;
            OP_WRITE: begin
                if (addr_ok) begin
                    regs_d[idx] = din;
                    if (!ctl_q.was_wr) begin
                        ctl_d.stb      = 1'b1;
                        ctl_d.stb_addr = idx;
                        ctl_d.stb_data = din;
                        ctl_d.restart  = (idx == IDX_W'(SHAPE_IDX));
                    end
                end
            end
            default: ;
        endcase
        ctl_d.was_wr = (op == OP_WRITE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            regs_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            regs_q <= regs_d;
        end
    end

    assign addr_o      = ctl_q.addr;
    assign regs_o      = regs_q;
    assign wr_stb      = ctl_q.stb;
    assign wr_addr     = ctl_q.stb_addr;
    assign wr_data     = ctl_q.stb_data;
    assign env_restart = ctl_q.restart;
endmodule

// File: rtl/psg_io_port.sv
module psg_io_port #(
    parameter int DATA_W  = 8,
    parameter int DIR_BIT = 6
) (
    input  logic [DATA_W-1:0] mix_reg,
    input  logic [DATA_W-1:0] port_reg,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic [DATA_W-1:0] rd_val
);
    always_comb begin
        pin_out = mix_reg[DIR_BIT] ? port_reg : '1;
        rd_val  = pin_in & pin_out;
    end
endmodule

// File: rtl/psg_bus_regfile.sv
module psg_bus_regfile
    import psg_bus_pkg::*;
#(
    parameter int DATA_W   = PSG_DW,
    parameter int NUM_REGS = PSG_NREG,
    parameter int NUM_PORTS = 2,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bdir,
    input  logic              bc2,
    input  logic              bc1,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    input  logic [DATA_W-1:0] port_a_in,
    input  logic [DATA_W-1:0] port_b_in,
    output logic [DATA_W-1:0] port_a_out,
    output logic [DATA_W-1:0] port_b_out,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              env_restart
);
    bus_op_e                          op;
    logic [DATA_W-1:0]                addr;
    logic [NUM_REGS-1:0][DATA_W-1:0]  regs;
    logic [NUM_PORTS-1:0][DATA_W-1:0] pin_in, pin_out, port_rd;
    logic [IDX_W-1:0]                 idx;
    logic [DATA_W-1:0]                rd_val;

    psg_bus_decode u_dec (
        .bdir (bdir),
        .bc2  (bc2),
        .bc1  (bc1),
        .op   (op)
    );

    psg_reg_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .din         (din),
        .addr_o      (addr),
        .regs_o      (regs),
        .wr_stb      (wr_stb),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .env_restart (env_restart)
    );

    assign pin_in[0] = port_a_in;
    assign pin_in[1] = port_b_in;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        psg_io_port #(.DATA_W(DATA_W), .DIR_BIT(PORT0_DIR + g)) u_port (
            .mix_reg  (regs[MIX_IDX]),
            .port_reg (regs[PORT0_IDX + g]),
            .pin_in   (pin_in[g]),
            .pin_out  (pin_out[g]),
            .rd_val   (port_rd[g])
        );
    end

    assign port_a_out = pin_out[0];
    assign port_b_out = pin_out[1];

    always_comb begin
        idx = addr[IDX_W-1:0];
        if (addr >= DATA_W'(NUM_REGS))
            rd_val = '1;
        else if (idx == IDX_W'(PORT0_IDX))
            rd_val = port_rd[0];
        else if (idx == IDX_W'(PORT0_IDX + 1))
            rd_val = port_rd[1];
        else
            rd_val = regs[idx] & reg_mask(idx);
        dout = (op == OP_READ) ? rd_val : '1;
    end
endmodule

// File: rtl/psg_bus_chk.sv
module psg_bus_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bdir,
    input logic       bc2,
    input logic       bc1,
    input logic [7:0] dout,
    input logic       wr_stb,
    input logic [3:0] wr_addr,
    input logic       env_restart
);
    // R4: bus output idles high outside a read
    a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bdir && bc2 && bc1) |-> dout == 8'hFF);

    // R8: strobe lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R8: strobe follows an edge that sampled a write
    a_r8_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(bdir && bc2 && !bc1));

    // R9: restart only with a shape register strobe
    a_r9_restart_only_shape: assert property (@(posedge clk) disable iff (!rst_n)
        env_restart |-> (wr_stb && wr_addr == 4'd13));

    // R9: every shape register strobe restarts
    a_r9_shape_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == 4'd13) |-> env_restart);
endmodule

bind psg_bus_regfile psg_bus_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bdir        (bdir),
    .bc2         (bc2),
    .bc1         (bc1),
    .dout        (dout),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .env_restart (env_restart)
);

// File: tb/sim_psg_bus_regfile.sv
`timescale 1ns/1ps
module sim_psg_bus_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bdir = 1'b0, bc2 = 1'b0, bc1 = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic [7:0] port_a_in = 8'hFF, port_b_in = 8'hFF;
    logic [7:0] port_a_out, port_b_out;
    logic       wr_stb;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic       env_restart;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic       s_stb, s_rst;
    logic [3:0] s_addr;
    logic [7:0] s_data;

    always #2 clk = ~clk;

    psg_bus_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bdir(bdir), .bc2(bc2), .bc1(bc1),
        .din(din), .dout(dout), .port_a_in(port_a_in), .port_b_in(port_b_in),
        .port_a_out(port_a_out), .port_b_out(port_b_out), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .env_restart(env_restart)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic set_bus(input logic [2:0] ctl, input logic [7:0] d);
        {bdir, bc2, bc1} = ctl;
        din = d;
    endtask

    task automatic latch(input logic [2:0] ctl, input logic [7:0] a);
        @(negedge clk) set_bus(ctl, a);
    endtask

    task automatic write_cur(input logic [7:0] d);
        @(negedge clk) set_bus(3'b110, d);
        @(negedge clk);
        s_stb = wr_stb; s_addr = wr_addr; s_data = wr_data; s_rst = env_restart;
        set_bus(3'b000, 8'h00);
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        latch(3'b111, a);
        write_cur(d);
    endtask

    task automatic read_cur(output logic [7:0] v);
        @(negedge clk) set_bus(3'b011, 8'h00);
        #1 v = dout;
        @(negedge clk) set_bus(3'b000, 8'h00);
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [7:0] v);
        latch(3'b111, a);
        read_cur(v);
    endtask

    function automatic logic [7:0] exp_mask(input int i);
        if (i == 1 || i == 3 || i == 5 || i == 13) return 8'h0F;
        if (i == 6 || i == 8 || i == 9 || i == 10) return 8'h1F;
        return 8'hFF;
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        #1;
        check("R10 port A after reset", port_a_out, 8'hFF);
        check("R10 port B after reset", port_b_out, 8'hFF);
        check("R10 strobe low after reset", {7'd0, wr_stb}, 8'h00);
        check("R4 idle dout after reset", dout, 8'hFF);
        read_cur(v);
        check("R10 register 0 cleared, address 0", v, 8'h00);
        read_reg(8'd7, v);
        check("R10 mixer cleared", v, 8'h00);
    endtask

    task automatic t_latch_combos();
        logic [7:0] v;
        latch(3'b100, 8'd0);
        write_cur(8'hA5);
        check("R2 write strobe after latch 100", {3'd0, s_stb, s_addr}, 8'h10);
        latch(3'b001, 8'd11);
        write_cur(8'h5A);
        check("R1 latch 001 strobe address", {3'd0, s_stb, s_addr}, 8'h1B);
        read_reg(8'd0, v);
        check("R1 latch 100 then R2 read", v, 8'hA5);
        read_reg(8'd11, v);
        check("R1 latch 001 then R2 read", v, 8'h5A);
    endtask

    task automatic t_idle();
        logic [7:0] v;
        latch(3'b111, 8'd0);
        @(negedge clk) set_bus(3'b000, 8'h77);
        #1 check("R4 pattern 000 dout", dout, 8'hFF);
        @(negedge clk) set_bus(3'b010, 8'h0B);
        #1 check("R4 pattern 010 dout", dout, 8'hFF);
        @(negedge clk) set_bus(3'b101, 8'h0B);
        #1 check("R4 pattern 101 dout", dout, 8'hFF);
        @(negedge clk) set_bus(3'b000, 8'h00);
        #1 check("R4 no strobe from inactive patterns", {7'd0, wr_stb}, 8'h00);
        read_cur(v);
        check("R4 address and register 0 untouched", v, 8'hA5);
    endtask

    task automatic t_masks();
        logic [7:0] v;
        for (int i = 0; i < 14; i++) begin
            if (i != 7) write_reg(8'(i), 8'hFF);
        end
        for (int i = 0; i < 14; i++) begin
            if (i != 7) begin
                read_reg(8'(i), v);
                check($sformatf("R5 mask of register %0d", i), v, exp_mask(i));
            end
        end
        write_reg(8'd7, 8'hFF);
        read_reg(8'd7, v);
        check("R5 mask of register 7", v, 8'hFF);
        write_reg(8'd7, 8'h00);
        write_reg(8'd0, 8'hA5);
    endtask

    task automatic t_high_addr();
        logic [7:0] v;
        write_reg(8'h10, 8'h99);
        check("R3 no strobe above 15", {7'd0, s_stb}, 8'h00);
        read_cur(v);
        check("R3 read above 15", v, 8'hFF);
        read_reg(8'd0, v);
        check("R3 register 0 kept", v, 8'hA5);
        read_reg(8'hF3, v);
        check("R3 read address F3", v, 8'hFF);
    endtask

    task automatic t_ports();
        logic [7:0] v;
        write_reg(8'd14, 8'hC3);
        write_reg(8'd15, 8'h3C);
        port_a_in = 8'h5A;
        port_b_in = 8'h96;
        #1;
        check("R6 port A input mode pins", port_a_out, 8'hFF);
        check("R6 port B input mode pins", port_b_out, 8'hFF);
        read_reg(8'd14, v);
        check("R7 port A input mode read", v, 8'h5A);
        write_reg(8'd7, 8'h40);
        check("R6 port A output mode pins", port_a_out, 8'hC3);
        check("R6 port B stays input", port_b_out, 8'hFF);
        port_a_in = 8'hF0;
        read_reg(8'd14, v);
        check("R7 port A output mode read", v, 8'hC0);
        read_reg(8'd15, v);
        check("R7 port B input mode read", v, 8'h96);
        write_reg(8'd7, 8'h80);
        check("R6 port A back to input", port_a_out, 8'hFF);
        check("R6 port B output mode pins", port_b_out, 8'h3C);
        port_b_in = 8'h0F;
        read_reg(8'd15, v);
        check("R7 port B output mode read", v, 8'h0C);
        write_reg(8'd7, 8'h00);
    endtask

    task automatic t_strobe();
        logic [7:0] v;
        int cnt = 0;
        logic [7:0] first = 8'h00;
        write_reg(8'd4, 8'h6E);
        check("R8 strobe seen", {7'd0, s_stb}, 8'h01);
        check("R8 strobe address", {4'd0, s_addr}, 8'h04);
        check("R8 strobe data", s_data, 8'h6E);
        latch(3'b111, 8'd2);
        @(negedge clk) set_bus(3'b110, 8'h11);
        @(negedge clk);
        if (wr_stb) begin cnt++; first = wr_data; end
        din = 8'h22;
        @(negedge clk);
        if (wr_stb) cnt++;
        din = 8'h33;
        @(negedge clk);
        if (wr_stb) cnt++;
        set_bus(3'b000, 8'h00);
        @(negedge clk);
        if (wr_stb) cnt++;
        check("R8 one strobe for a held write", 8'(cnt), 8'h01);
        check("R8 held write strobe data", first, 8'h11);
        read_reg(8'd2, v);
        check("R8 held write last value stored", v, 8'h33);
    endtask

    task automatic t_restart();
        logic [7:0] v;
        write_reg(8'd13, 8'hFA);
        check("R9 restart on shape write", {7'd0, s_rst}, 8'h01);
        check("R9 shape strobe address", {4'd0, s_addr}, 8'h0D);
        write_reg(8'd12, 8'h44);
        check("R9 no restart on register 12", {7'd0, s_rst}, 8'h00);
        read_reg(8'd13, v);
        check("R5 shape readback masked", v, 8'h0A);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch_combos();
        t_idle();
        t_masks();
        t_high_addr();
        t_ports();
        t_strobe();
        t_restart();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end
endmodule